// File: doc/BRIEF.md
# Load/Store Lane Aligner

This block sits between a 32-bit core datapath and a word-wide data memory port. It takes one load or store request at a time. For the request it forms a word-aligned memory address and per-lane byte enables. For a store it places the operand bytes on the memory lanes. For a load it picks the addressed bytes out of the returned word and widens them to 32 bits. The byte order is chosen per access by an endianness input, which is captured when the request is accepted.

An access of 1, 2 or 4 bytes is legal only at an address that is a multiple of its size. An illegal access never reaches memory. Instead, the block answers with a fault response that carries the offending address. The core issues a request while `req_ready` is high, then waits for the single-cycle `rsp_valid` pulse.

Top module: `ls_align_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_req` and `rsp_valid` are low, `mem_be` is zero, and `req_ready` is high.
- R2: The size code is 0 for byte, 1 for halfword, 2 for word and 3 for illegal. `mem_addr` is the request address with its two low bits cleared.
- R3: Byte enables apply to loads and stores. For a byte at offset o, the lane is o when little-endian and 3-o when big-endian. A little-endian halfword uses lanes 1:0 at offset 0 and lanes 3:2 at offset 2. A big-endian halfword uses lanes 3:2 at offset 0 and lanes 1:0 at offset 2. A word enables all four lanes.
- R4: Store data is laid out as follows. A byte operand (bits 7:0) is repeated in all four lanes. A halfword operand (bits 15:0) is repeated in both halves. A word is passed unchanged. `mem_wdata` is zero for loads.
- R5: A load result is taken from the lanes selected by R3. For a halfword, the higher-numbered lane of the pair supplies result bits 15:8.
- R6: When the signed flag is 1, a byte or halfword load is sign-extended to 32 bits; when it is 0, the load is zero-extended. A word load ignores the flag.
- R7: An access faults when it is a halfword at an odd address, a word at an address that is not a multiple of 4, or uses size code 3. In the cycle after acceptance, a fault gives `rsp_valid`, `rsp_fault` and `rsp_fault_addr` equal to the request address. `mem_req` stays low for the whole access.
- R8: For a legal access, `mem_req` is high for exactly the one cycle after acceptance. A store raises `rsp_valid` in the next cycle. A load samples `mem_rdata` in the cycle after `mem_req`, and raises `rsp_valid` with the result in the cycle after that.
- R9: `req_ready` is low from acceptance until the response cycle ends. A request presented while `req_ready` is low is ignored.
- R10: `big_endian` is sampled only at acceptance. Changing it during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_signed | input | 1 | Sign-extend byte/halfword load |
| big_endian | input | 1 | Byte order for this access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store operand, right-justified |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Lane enables |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Word returned one cycle after `mem_req` |
| rsp_valid | output | 1 | Access complete |
| rsp_fault | output | 1 | Access refused as misaligned |
| rsp_fault_addr | output | ADDR_W | Address of the refused access |
| rsp_rdata | output | 32 | Extended load result |

## Verification
Loads read one fixed word whose four lanes hold distinct values, with the top lane above 0x7F. Each result therefore shows which lane was read and whether sign fill came from the correct byte. Every size is tried in both byte orders at offsets whose lane differs between the two orders, so a swapped or ignored endianness shows up as a wrong enable or a wrong value. Stores use operands whose bytes all differ, so lane replication and pass-through can be distinguished. A halfword at an odd address, a word at offset 2 and size code 3 each test the fault path. Directed runs flip the byte order in mid-access and hold a second request during a busy cycle.

// File: rtl/lsa_pkg.sv
// Package: shared sizes and helpers for the load/store lane aligner.
// Assumes a power-of-two lane count; word size equals the full bus.
package lsa_pkg;
    localparam int unsigned LANES  = 4;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned WORD_W = LANES * LANE_W;
    localparam int unsigned OFS_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    // Element byte count minus one, as a lane-offset mask.
    function automatic logic [OFS_W-1:0] size_mask(acc_size_e sz);
        case (sz)
            SZ_BYTE: return '0;
            SZ_HALF: return OFS_W'(1);
            default: return '1;
        endcase
    endfunction
endpackage

// File: rtl/lsa_misalign.sv
// Misalignment detector: flags any access whose offset is not a multiple
// of its size, and the illegal size code. Purely combinational.
module lsa_misalign
    import lsa_pkg::*;
#(
    parameter int unsigned NLANES = LANES
) (
    input  acc_size_e                   size,
    input  logic [$clog2(NLANES)-1:0]   ofs,
    output logic                        bad
);
    // Decide legality from size and low address bits.
    always_comb begin
        case (size)
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = ofs[0];
            SZ_WORD: bad = |ofs;
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsa_store_steer.sv
// Store steering: per-lane byte enables and lane data for one access.
// Each lane carries operand byte (lane index mod element size); this holds
// for both byte orders because elements are naturally aligned.
module lsa_store_steer
    import lsa_pkg::*;
#(
    parameter int unsigned NLANES = LANES,
    parameter int unsigned BYTE_W = LANE_W
) (
    input  acc_size_e                       size,
    input  logic [$clog2(NLANES)-1:0]       ofs,
    input  logic                            big,
    input  logic [NLANES*BYTE_W-1:0]        wdata_in,
    output logic [NLANES-1:0]               be,
    output logic [NLANES*BYTE_W-1:0]        wdata_out
);
    localparam int unsigned OW = $clog2(NLANES);

    logic [OW-1:0] msk;
    assign msk = size_mask(size);

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        localparam logic [OW-1:0] LI = OW'(i);
        logic [OW-1:0] lane_ofs;
        logic [OW-1:0] src;
        // Address offset held by this lane under the chosen byte order.
        assign lane_ofs = big ? ~LI : LI;
        assign src      = LI & msk;
        assign be[i]    = (lane_ofs & ~msk) == (ofs & ~msk);
        assign wdata_out[i*BYTE_W +: BYTE_W] = wdata_in[src*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/lsa_load_extend.sv
// Load extraction: gathers the element from its lanes and sign- or
// zero-extends it to the full word. Purely combinational.
module lsa_load_extend
    import lsa_pkg::*;
#(
    parameter int unsigned NLANES = LANES,
    parameter int unsigned BYTE_W = LANE_W
) (
    input  acc_size_e                       size,
    input  logic [$clog2(NLANES)-1:0]       ofs,
    input  logic                            big,
    input  logic                            sgn,
    input  logic [NLANES*BYTE_W-1:0]        rdata,
    output logic [NLANES*BYTE_W-1:0]        result
);
    localparam int unsigned OW = $clog2(NLANES);

    logic [OW-1:0] msk;
    logic [OW-1:0] grp;
    logic [OW-1:0] top_lane;
    logic          fill;

    assign msk      = size_mask(size);
    assign grp      = (big ? ~ofs : ofs) & ~msk;
    assign top_lane = grp | msk;
    assign fill     = sgn & rdata[top_lane*BYTE_W + BYTE_W - 1];

    for (genvar k = 0; k < NLANES; k++) begin : g_byte
        localparam logic [OW-1:0] KI = OW'(k);
        logic [OW-1:0] lane_k;
        // Element byte k lives in lane grp|k; bytes past the element get fill.
        assign lane_k = grp | (KI & msk);
        assign result[k*BYTE_W +: BYTE_W] = ((KI & ~msk) == '0)
            ? rdata[lane_k*BYTE_W +: BYTE_W]
            : {BYTE_W{fill}};
    end
endmodule

// File: rtl/ls_align_unit.sv
// Load/store lane aligner top. Accepts one request when idle, captures all
// request fields (including byte order), issues a single-cycle memory
// access or a fault response, and returns the load result two cycles after
// the memory strobe. Assumes memory returns read data one cycle after mem_req.
module ls_align_unit
    import lsa_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic                req_signed,
    input  logic                big_endian,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [WORD_W-1:0]   req_wdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [LANES-1:0]    mem_be,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                rsp_valid,
    output logic                rsp_fault,
    output logic [ADDR_W-1:0]   rsp_fault_addr,
    output logic [WORD_W-1:0]   rsp_rdata
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_ISSUE, ST_CAPTURE, ST_RESP, ST_FAULT
    } st_e;

    st_e                state;
    logic [ADDR_W-1:0]  cap_addr;
    acc_size_e          cap_size;
    logic               cap_sgn;
    logic               cap_big;
    logic               cap_wr;
    logic [WORD_W-1:0]  cap_wdata;
    logic [WORD_W-1:0]  load_q;

    logic               misal;
    logic               accept;
    logic [LANES-1:0]   steer_be;
    logic [WORD_W-1:0]  steer_wdata;
    logic [WORD_W-1:0]  ext_data;

    assign accept = req_valid && (state == ST_IDLE);

    lsa_misalign #(.NLANES(LANES)) u_misalign (
        .size (acc_size_e'(req_size)),
        .ofs  (req_addr[OFS_W-1:0]),
        .bad  (misal)
    );

    lsa_store_steer #(.NLANES(LANES), .BYTE_W(LANE_W)) u_steer (
        .size      (cap_size),
        .ofs       (cap_addr[OFS_W-1:0]),
        .big       (cap_big),
        .wdata_in  (cap_wdata),
        .be        (steer_be),
        .wdata_out (steer_wdata)
    );

    lsa_load_extend #(.NLANES(LANES), .BYTE_W(LANE_W)) u_extend (
        .size   (cap_size),
        .ofs    (cap_addr[OFS_W-1:0]),
        .big    (cap_big),
        .sgn    (cap_sgn),
        .rdata  (mem_rdata),
        .result (ext_data)
    );

    // Sequencer: capture request, issue, collect load data, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cap_addr  <= '0;
            cap_size  <= SZ_BYTE;
            cap_sgn   <= 1'b0;
            cap_big   <= 1'b0;
            cap_wr    <= 1'b0;
            cap_wdata <= '0;
            load_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cap_addr  <= req_addr;
                        cap_size  <= acc_size_e'(req_size);
                        cap_sgn   <= req_signed;
                        cap_big   <= big_endian;
                        cap_wr    <= req_write;
                        cap_wdata <= req_wdata;
                        state     <= misal ? ST_FAULT : ST_ISSUE;
                    end
                end
                ST_ISSUE:   state <= cap_wr ? ST_RESP : ST_CAPTURE;
                ST_CAPTURE: begin
                    load_q <= ext_data;
                    state  <= ST_RESP;
                end
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // Port drive: memory side only in the issue cycle, response side after.
    always_comb begin
        req_ready      = (state == ST_IDLE);
        mem_req        = (state == ST_ISSUE);
        mem_we         = mem_req && cap_wr;
        mem_addr       = mem_req ? {cap_addr[ADDR_W-1:OFS_W], OFS_W'(0)} : '0;
        mem_be         = mem_req ? steer_be : '0;
        mem_wdata      = mem_we ? steer_wdata : '0;
        rsp_valid      = (state == ST_RESP) || (state == ST_FAULT);
        rsp_fault      = (state == ST_FAULT);
        rsp_fault_addr = rsp_fault ? cap_addr : '0;
        rsp_rdata      = ((state == ST_RESP) && !cap_wr) ? load_q : '0;
    end

    // Checks guarding the sequencer and the steering outputs.
    assert_fault_suppress_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && misal) |=> (rsp_valid && rsp_fault && !mem_req));

    assert_issue_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !misal) |=> (mem_req && !rsp_valid));

    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || rsp_valid) |-> !req_ready);

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_be_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == (1 << cap_size)));

    assert_zero_extend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && !cap_wr && !cap_sgn && cap_size == SZ_BYTE)
            |-> (rsp_rdata[WORD_W-1:LANE_W] == '0));
endmodule

// File: tb/ls_align_unit_bench.sv
`timescale 1ns/1ps
module ls_align_unit_bench;
    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic        sgn;
        logic        big;
        logic [1:0]  off;
        logic [31:0] dat;
        logic [3:0]  exp_be;
        logic [31:0] exp_dat;
        logic        flt;
    } vec_t;

    localparam logic [31:0] RD = 32'h8A7B_6C5D;
    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 1'b0, 1'b0, 2'd1, 32'h0000_00A5, 4'b0010, 32'hA5A5_A5A5, 1'b0},
        '{1'b1, 2'd0, 1'b0, 1'b1, 2'd1, 32'h0000_00A5, 4'b0100, 32'hA5A5_A5A5, 1'b0},
        '{1'b1, 2'd1, 1'b0, 1'b0, 2'd2, 32'h1234_BEEF, 4'b1100, 32'hBEEF_BEEF, 1'b0},
        '{1'b1, 2'd1, 1'b0, 1'b1, 2'd2, 32'h1234_BEEF, 4'b0011, 32'hBEEF_BEEF, 1'b0},
        '{1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 32'hCAFE_0123, 4'b1111, 32'hCAFE_0123, 1'b0},
        '{1'b1, 2'd1, 1'b0, 1'b1, 2'd0, 32'h1234_BEEF, 4'b1100, 32'hBEEF_BEEF, 1'b0},
        '{1'b0, 2'd0, 1'b1, 1'b0, 2'd3, RD,            4'b1000, 32'hFFFF_FF8A, 1'b0},
        '{1'b0, 2'd0, 1'b0, 1'b0, 2'd3, RD,            4'b1000, 32'h0000_008A, 1'b0},
        '{1'b0, 2'd0, 1'b1, 1'b1, 2'd3, RD,            4'b0001, 32'h0000_005D, 1'b0},
        '{1'b0, 2'd0, 1'b1, 1'b1, 2'd0, RD,            4'b1000, 32'hFFFF_FF8A, 1'b0},
        '{1'b0, 2'd1, 1'b1, 1'b0, 2'd0, RD,            4'b0011, 32'h0000_6C5D, 1'b0},
        '{1'b0, 2'd1, 1'b1, 1'b0, 2'd2, RD,            4'b1100, 32'hFFFF_8A7B, 1'b0},
        '{1'b0, 2'd1, 1'b0, 1'b1, 2'd0, RD,            4'b1100, 32'h0000_8A7B, 1'b0},
        '{1'b0, 2'd1, 1'b1, 1'b1, 2'd2, RD,            4'b0011, 32'h0000_6C5D, 1'b0},
        '{1'b0, 2'd2, 1'b1, 1'b1, 2'd0, RD,            4'b1111, 32'h8A7B_6C5D, 1'b0},
        '{1'b1, 2'd1, 1'b0, 1'b0, 2'd1, 32'h0000_1111, 4'b0000, 32'h0,         1'b1},
        '{1'b0, 2'd2, 1'b0, 1'b1, 2'd2, RD,            4'b0000, 32'h0,         1'b1},
        '{1'b1, 2'd3, 1'b0, 1'b0, 2'd0, 32'h0000_2222, 4'b0000, 32'h0,         1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_signed = 1'b0;
    logic        big_endian = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_fault_addr;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ls_align_unit #(.ADDR_W(32)) u_ls_align_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_signed(req_signed), .big_endian(big_endian),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_fault_addr(rsp_fault_addr), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One access from the table; samples each cycle at the falling edge.
    task automatic run_vec(input vec_t v, input int idx);
        logic [31:0] a;
        a = BASE + {30'd0, v.off};
        @(negedge clk);
        req_valid = 1'b1; req_write = v.wr; req_size = v.sz;
        req_signed = v.sgn; big_endian = v.big; req_addr = a;
        req_wdata = v.wr ? v.dat : 32'h0; mem_rdata = v.wr ? 32'h0 : v.dat;
        @(negedge clk);
        req_valid = 1'b0;
        if (v.flt) begin
            chk(rsp_valid && rsp_fault, "R7", $sformatf("vec%0d fault rsp", idx),
                {30'd0, rsp_valid, rsp_fault}, 32'h3);
            chk(rsp_fault_addr == a, "R7", $sformatf("vec%0d fault addr", idx), rsp_fault_addr, a);
            chk(!mem_req && mem_be == 4'b0, "R7", $sformatf("vec%0d no mem", idx),
                {27'd0, mem_req, mem_be}, 32'h0);
            @(negedge clk);
            chk(!mem_req && !rsp_valid && req_ready, "R7", $sformatf("vec%0d after fault", idx),
                {29'd0, mem_req, rsp_valid, req_ready}, 32'h1);
            return;
        end
        chk(mem_req && mem_we == v.wr && !rsp_valid, "R8", $sformatf("vec%0d strobe", idx),
            {29'd0, mem_req, mem_we, rsp_valid}, {29'd0, 1'b1, v.wr, 1'b0});
        chk(mem_addr == BASE, "R2", $sformatf("vec%0d addr", idx), mem_addr, BASE);
        chk(mem_be == v.exp_be, "R3", $sformatf("vec%0d be", idx),
            {28'd0, mem_be}, {28'd0, v.exp_be});
        if (v.wr)
            chk(mem_wdata == v.exp_dat, "R4", $sformatf("vec%0d wdata", idx), mem_wdata, v.exp_dat);
        else
            chk(mem_wdata == 32'h0, "R4", $sformatf("vec%0d load wdata", idx), mem_wdata, 32'h0);
        @(negedge clk);
        if (v.wr) begin
            chk(rsp_valid && !rsp_fault && !mem_req, "R8", $sformatf("vec%0d store done", idx),
                {29'd0, rsp_valid, rsp_fault, mem_req}, 32'h4);
        end else begin
            chk(!rsp_valid && !mem_req, "R8", $sformatf("vec%0d load wait", idx),
                {30'd0, rsp_valid, mem_req}, 32'h0);
            @(negedge clk);
            mem_rdata = 32'hDEAD_0000;
            chk(rsp_valid && !rsp_fault, "R8", $sformatf("vec%0d load done", idx),
                {30'd0, rsp_valid, rsp_fault}, 32'h2);
            chk(rsp_rdata == v.exp_dat, "R5 R6", $sformatf("vec%0d load data", idx),
                rsp_rdata, v.exp_dat);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!mem_req && !rsp_valid && mem_be == 4'b0 && req_ready, "R1", "during reset",
            {26'd0, mem_req, rsp_valid, mem_be}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && !rsp_valid && req_ready, "R1", "after reset",
            {29'd0, mem_req, rsp_valid, req_ready}, 32'h1);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R10: byte order flipped after acceptance must not affect the access
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size = 2'd0; req_signed = 1'b0;
        big_endian = 1'b0; req_addr = BASE; mem_rdata = RD;
        @(negedge clk);
        req_valid = 1'b0; big_endian = 1'b1;
        chk(mem_be == 4'b0001, "R10", "be after flip", {28'd0, mem_be}, 32'h1);
        @(negedge clk);
        @(negedge clk);
        chk(rsp_valid && rsp_rdata == 32'h0000_005D, "R10", "data after flip",
            rsp_rdata, 32'h0000_005D);

        // R9: request held while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0; big_endian = 1'b0;
        req_addr = BASE; req_wdata = 32'h0000_0077;
        @(negedge clk);
        req_size = 2'd2; req_addr = 32'h0000_2000; req_wdata = 32'h1357_9BDF;
        chk(!req_ready && mem_addr == BASE && mem_be == 4'b0001, "R9", "busy issue",
            mem_addr, BASE);
        @(negedge clk);
        chk(!req_ready && rsp_valid && !mem_req, "R9", "busy resp",
            {29'd0, req_ready, rsp_valid, mem_req}, 32'h2);
        req_valid = 1'b0;
        @(negedge clk);
        chk(!mem_req && !rsp_valid && req_ready, "R9", "second request dropped",
            {29'd0, mem_req, rsp_valid, req_ready}, 32'h1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule